// File: doc/BRIEF.md
# Write-Order Hazard Detector for Mixed-Latency Writeback

This block sits beside the issue stage of an in-order pipeline in which two instruction classes reach register writeback after different numbers of stages. A load goes through execute and then two memory stages before writeback. An ALU operation goes from execute straight to writeback. Because of this, a younger ALU operation can write a register before an older load that targets the same register. The block prevents that inversion. It stalls the issuing instruction for as long as its write would land at or before the pending write of an older, slower instruction to the same register.

For each in-flight writer, the detector keeps a small record: the destination register and the number of pipeline advances left until that writer reaches writeback. When the pipeline advances and an instruction issues, a record is created for it. Each further advance counts the record down, and the record falls out once its writer is in writeback. A stalled instruction is checked again on every cycle and issues once no conflicting record is left. Operand forwarding and the datapath are handled elsewhere.

Top module: `waw_guard`

## Requirements
- R1: After reset the record store is empty, so no issuing instruction stalls until a new writer has issued. Reset is asynchronous and active low.
- R2: An instruction issues on a cycle with `advance`=1, `iss_valid`=1 and `stall`=0. A load (`iss_is_load`=1) reaches writeback 4 advances after it issues, and an ALU operation (`iss_is_load`=0) reaches writeback 2 advances after it issues.
- R3: If an ALU operation presents the same destination as a load that issued one advance earlier, `stall` is 1 for exactly two advancing cycles and 0 on the third.
- R4: If the ALU operation presents the same destination two advances after the load, it stalls for one cycle. Three advances after the load, it does not stall.
- R5: Pairs with equal latency never stall: a load after a load, or an ALU operation after an ALU operation. An ALU operation followed by a load never stalls either.
- R6: Register 0, and instructions with `iss_has_dest`=0, never stall and leave no record behind.
- R7: A matching destination is required. An ALU operation to a different register than the pending load issues without a stall.
- R8: While `advance`=0 the records do not count down, and an existing stall is held.
- R9: `stall` is 0 whenever `iss_valid` is 0.
- R10: At any time, among the pending writers to one register, the younger one always has strictly more advances left before writeback than the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_is_load | input | 1 | 1 = load (long writeback path), 0 = ALU operation |
| iss_has_dest | input | 1 | The instruction writes a register |
| iss_dest | input | $clog2(NREG) | Destination register number |
| advance | input | 1 | The pipeline moves forward this cycle |
| stall | output | 1 | Hold the presented instruction in the issue stage |

## Verification
A wrong record inside the block shows up at `stall`, which is a combinational output, and it shows up on the first cycle in which a conflicting instruction is presented. A countdown that decrements one step too few or too many shifts how long a stall lasts by one cycle, so every stall window is checked edge by edge. A dropped record shows up as a missing stall. A stale record, for example one that survives reset or that was wrongly made for register 0, shows up as an unwanted stall. A frozen-pipeline scenario separates counting on `advance` from counting on the clock.

// File: rtl/waw_guard.sv
module waw_guard #(
  parameter int NREG     = 32,
  parameter int LOAD_LAT = 4,
  parameter int ALU_LAT  = 2,
  localparam int RW    = $clog2(NREG),
  localparam int CW    = $clog2(LOAD_LAT + 1),
  localparam int NSLOT = LOAD_LAT - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_is_load,
  input  logic          iss_has_dest,
  input  logic [RW-1:0] iss_dest,
  input  logic          advance,
  output logic          stall
);

  logic [RW-1:0]    sl_dest [NSLOT];
  logic [CW-1:0]    sl_cnt  [NSLOT];
  logic [NSLOT-1:0] hit;

  wire          writes  = iss_valid && iss_has_dest && (iss_dest != '0);
  wire [CW-1:0] new_lat = iss_is_load ? CW'(LOAD_LAT) : CW'(ALU_LAT);
  wire          take    = advance && writes && !stall;

  always_comb
    for (int k = 0; k < NSLOT; k++)
      hit[k] = (sl_cnt[k] != '0) && (sl_dest[k] == iss_dest) && (sl_cnt[k] >= new_lat);

  assign stall = writes && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) begin
        sl_cnt[k]  <= '0;
        sl_dest[k] <= '0;
      end
    end else if (advance) begin
      sl_cnt[0]  <= take ? new_lat - CW'(1) : '0;
      sl_dest[0] <= iss_dest;
      for (int k = 1; k < NSLOT; k++) begin
        sl_cnt[k]  <= (sl_cnt[k-1] == '0) ? '0 : sl_cnt[k-1] - CW'(1);
        sl_dest[k] <= sl_dest[k-1];
      end
    end
  end

  a_r9_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);

  a_r6_reg0_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_dest == '0 || !iss_has_dest) |-> !stall);

  a_r5_load_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_is_load) |-> !stall);

  a_r8_frozen_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !advance) |=> (stall || !$stable(iss_dest) || !$stable(iss_is_load)
                             || !$stable(iss_valid) || !$stable(iss_has_dest)));

  for (genvar i = 0; i < NSLOT; i++) begin : g_ord_i
    for (genvar j = i + 1; j < NSLOT; j++) begin : g_ord_j
      a_r10_younger_writes_later: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_cnt[i] != '0 && sl_cnt[j] != '0 && sl_dest[i] == sl_dest[j])
          |-> (sl_cnt[i] > sl_cnt[j]));
    end
  end

endmodule

// File: tb/waw_guard_test.sv
module waw_guard_test;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_is_load = 0, iss_has_dest = 0, advance = 0;
  logic [4:0] iss_dest = '0;
  logic stall;
  int tests = 0, failed = 0;
  bit done = 0;

  waw_guard uut (.clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_is_load(iss_is_load),
                 .iss_has_dest(iss_has_dest), .iss_dest(iss_dest), .advance(advance), .stall(stall));

  always #2 clk = ~clk;

  task automatic put(input logic v, input logic ld, input logic [4:0] d, input logic hd, input logic adv);
    @(negedge clk);
    iss_valid = v; iss_is_load = ld; iss_dest = d; iss_has_dest = hd; advance = adv;
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    tests++;
    if (stall !== exp) begin
      failed++;
      $display("FAIL %s: stall=%0b expected %0b", tag, stall, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0, 0, 0, 1);
  endtask

  task automatic t_reset;
    put(1, 0, 5'd1, 1, 1); chk(0, "R1 empty after reset");
    put(1, 1, 5'd1, 1, 1); chk(0, "R1 load after reset");
    rst_n = 0; #1; rst_n = 1;
    put(1, 0, 5'd1, 1, 1); chk(0, "R1 record cleared by reset");
    idle(4);
  endtask

  task automatic t_gap1;
    put(1, 1, 5'd3, 1, 1); chk(0, "R3 load issues");
    put(1, 0, 5'd3, 1, 1); chk(1, "R3 stall cycle 1");
    put(1, 0, 5'd3, 1, 1); chk(1, "R3 stall cycle 2");
    put(1, 0, 5'd3, 1, 1); chk(0, "R3 released after two");
    idle(4);
  endtask

  task automatic t_gap23;
    put(1, 1, 5'd4, 1, 1); chk(0, "R4 load issues");
    put(0, 0, 5'd0, 0, 1);
    put(1, 0, 5'd4, 1, 1); chk(1, "R4 gap two stalls once");
    put(1, 0, 5'd4, 1, 1); chk(0, "R4 gap two released");
    idle(4);
    put(1, 1, 5'd4, 1, 1);
    put(0, 0, 5'd0, 0, 1);
    put(0, 0, 5'd0, 0, 1);
    put(1, 0, 5'd4, 1, 1); chk(0, "R4 gap three no stall");
    idle(4);
  endtask

  task automatic t_same_lat;
    put(1, 1, 5'd6, 1, 1);
    put(1, 1, 5'd6, 1, 1); chk(0, "R5 load after load");
    idle(4);
    put(1, 0, 5'd7, 1, 1);
    put(1, 0, 5'd7, 1, 1); chk(0, "R5 alu after alu");
    put(1, 1, 5'd7, 1, 1); chk(0, "R5 load after alu");
    idle(4);
  endtask

  task automatic t_nodest;
    put(1, 1, 5'd0, 1, 1);
    put(1, 0, 5'd0, 1, 1); chk(0, "R6 register 0");
    idle(4);
    put(1, 1, 5'd9, 0, 1);
    put(1, 0, 5'd9, 1, 1); chk(0, "R6 no-dest load leaves no record");
    idle(4);
    put(1, 1, 5'd9, 1, 1);
    put(1, 0, 5'd9, 0, 1); chk(0, "R6 no-dest alu ignored");
    idle(4);
  endtask

  task automatic t_other_dest;
    put(1, 1, 5'd10, 1, 1);
    put(1, 0, 5'd11, 1, 1); chk(0, "R7 different dest");
    idle(4);
  endtask

  task automatic t_frozen;
    put(1, 1, 5'd12, 1, 1);
    for (int i = 0; i < 3; i++) begin
      put(1, 0, 5'd12, 1, 0); chk(1, "R8 held while frozen");
    end
    put(1, 0, 5'd12, 1, 1); chk(1, "R8 resume stall 1");
    put(1, 0, 5'd12, 1, 1); chk(1, "R8 resume stall 2");
    put(1, 0, 5'd12, 1, 1); chk(0, "R8 resume released");
    idle(4);
  endtask

  task automatic t_valid;
    put(1, 1, 5'd13, 1, 1);
    put(0, 0, 5'd13, 1, 1); chk(0, "R9 invalid never stalls");
    put(1, 0, 5'd13, 1, 1); chk(1, "R2 load still pending");
    idle(4);
  endtask

  initial begin
    #10 rst_n = 1;
    t_reset; t_gap1; t_gap23; t_same_lat; t_nodest; t_other_dest; t_frozen; t_valid;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: stall=%0b expected completion", stall);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule